// File: doc/BRIEF.md
# Split Dual 16-bit One-Shot Timer

This block is a 32-bit timer peripheral whose register set is divided into two independent 16-bit timers. Half A occupies bits 15:0 of every register and half B occupies bits 31:16. Each half has its own run bit, clock-enable bit, power-of-two prescaler, interrupt-enable bit, 16-bit counter, 16-bit compare value and hit flag. Software uses a half as a one-shot delay: it loads the counter with 1, writes a compare value, starts the half, and waits for the hit flag or the shared interrupt line.

Handshake bits let software pace its configuration. A clock-ready bit follows the clock-enable bit, a running bit confirms the start, and a load-done bit shows that a counter write has taken effect. The hit and load-done flags are cleared by writing 1 to them, one half at a time. A plain register bus carries all accesses: a write strobe, a 2-bit word address, 32-bit write data that always writes the whole word, and combinational read data.

Top module: `split_oneshot_timer`

## Requirements
- R1: After reset all four registers read 0 and `irq` and `irq_sel` are 0.
- R2: Word address 0 is control, 1 count, 2 compare, 3 status. Half A's fields sit in bits 15:0 and half B's in bits 31:16, with identical positions within each half. A compare write reads back unchanged.
- R3: Control bit 1 (clock enable) sets status bit 2 (clock ready) one cycle after the write. A half whose clock-ready bit is 0 holds its count even with its run bit set.
- R4: With clock ready, setting control bit 0 (run) sets status bit 3 (running) one cycle after the write.
- R5: A count write loads the counter one cycle after the write and sets status bit 1 (load done) at the same edge. Load done reads 0 in the cycle right after a count write. Writing 1 to it clears it for that half only.
- R6: Control bits 5:2 hold the prescale exponent N; a half counts once per 2^N clocks, values above 12 act as 12, and the prescale counter restarts whenever the half stops. From a count of S and a compare value C > S, the hit flag reads 1 exactly (C-S)*2^N+1 cycles after the start write.
- R7: When a running half's count equals its compare value, status bit 0 (hit) sets, the run bit clears, and the count stays equal to the compare value.
- R8: Writing 1 to a half's hit bit clears it and leaves the other half's hit bit unchanged.
- R9: Control bit 6 (interrupt enable) gates a half's hit flag onto `irq`. When both halves have a gated hit pending, `irq_sel` is 0 (half A). It is 1 only when half B alone is pending.
- R10: Clearing the run bit stops the count at once, and the count is held. Setting the run bit again without a reload continues from the held value.
- R11: The two halves count and hit independently when started together with different settings.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| bus_we | input | 1 | Write strobe for the addressed word |
| bus_addr | input | 2 | Word address: 0 control, 1 count, 2 compare, 3 status |
| bus_wdata | input | 32 | Write data (whole word) |
| bus_rdata | output | 32 | Read data for `bus_addr` |
| irq | output | 1 | Shared interrupt: any enabled hit flag |
| irq_sel | output | 1 | 0 = half A to be serviced, 1 = only half B pending |

## Verification
Assertions check on every cycle that a compare match leaves the hit flag set and the run bit clear, and that a stopped half's count never moves except through a load. They also check that a lone count write is followed by load done, that a hit clear by software takes effect, that the prescaler never ticks in its first cycle when N is above 0, and that half A wins the interrupt selector. Only the bench's scenarios can show the exact latency formula for several exponents, including the clamp at 12. The same holds for the resume-from-held-count timing, the independence of two halves started together, and the gating of the interrupt by its enable bit.

// File: rtl/halftmr_pkg.sv
package halftmr_pkg;
  // Control field positions within one half
  localparam int CTRL_RUN     = 0;
  localparam int CTRL_CLK     = 1;
  localparam int CTRL_SCL_LSB = 2;
  localparam int SCALE_W      = 4;
  localparam int CTRL_IE      = CTRL_SCL_LSB + SCALE_W;
  // Status field positions within one half
  localparam int ST_HIT  = 0;
  localparam int ST_DONE = 1;
  localparam int ST_RDY  = 2;
  localparam int ST_RUN  = 3;

  typedef enum logic [1:0] {
    REG_CTRL  = 2'd0,
    REG_COUNT = 2'd1,
    REG_CMP   = 2'd2,
    REG_STAT  = 2'd3
  } reg_sel_e;

  // Prescale terminal count: 2^min(s, max_e) - 1
  function automatic int unsigned period_mask(input logic [SCALE_W-1:0] s,
                                               input int unsigned max_e);
    int unsigned e;
    e = int'(s);
    if (e > max_e) e = max_e;
    return (32'd1 << e) - 32'd1;
  endfunction
endpackage

// File: rtl/halftmr_prescale.sv
module halftmr_prescale
  import halftmr_pkg::*;
#(
  parameter int MAX_EXP = 12
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               en,
  input  logic [SCALE_W-1:0] scale,
  output logic               tick
);
  localparam int PRE_W = (MAX_EXP > 0) ? MAX_EXP : 1;

  logic [PRE_W-1:0] pre_q;
  logic [PRE_W-1:0] limit;

  assign limit = PRE_W'(period_mask(scale, MAX_EXP));
  assign tick  = en && (pre_q == limit);

  always_ff @(posedge clk) begin
    if (!rst_n)      pre_q <= '0;
    else if (!en)    pre_q <= '0;
    else if (tick)   pre_q <= '0;
    else             pre_q <= pre_q + 1'b1;
  end

  // R6: the first tick after a start is a full prescaled period away
  a_r6_full_first_period: assert property (@(posedge clk) disable iff (!rst_n)
    ($rose(en) && (limit != '0)) |-> !tick);
endmodule

// File: rtl/halftmr_unit.sv
module halftmr_unit
  import halftmr_pkg::*;
#(
  parameter int HALF_W  = 16,
  parameter int MAX_EXP = 12
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              ctrl_we,
  input  logic              cnt_we,
  input  logic              cmp_we,
  input  logic              stat_we,
  input  logic [HALF_W-1:0] wdata,
  output logic [HALF_W-1:0] ctrl_q,
  output logic [HALF_W-1:0] cnt_q,
  output logic [HALF_W-1:0] cmp_q,
  output logic [HALF_W-1:0] stat_q,
  output logic              irq_o
);
  logic               run_q, clk_on_q, ie_q;
  logic [SCALE_W-1:0] scale_q;
  logic               rdy_q, runok_q;
  logic [HALF_W-1:0]  cnt_r, cmp_r, pend_val;
  logic               pend_q, done_q, hit_q;

  // Named internal events
  logic active;
  logic tick;
  logic match_ev;

  assign active   = run_q && rdy_q;
  assign match_ev = active && (cnt_r == cmp_r);

  halftmr_prescale #(.MAX_EXP(MAX_EXP)) u_pre (
    .clk  (clk),
    .rst_n(rst_n),
    .en   (active),
    .scale(scale_q),
    .tick (tick)
  );

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      run_q    <= 1'b0;
      clk_on_q <= 1'b0;
      ie_q     <= 1'b0;
      scale_q  <= '0;
      rdy_q    <= 1'b0;
      runok_q  <= 1'b0;
      cnt_r    <= '0;
      cmp_r    <= '0;
      pend_val <= '0;
      pend_q   <= 1'b0;
      done_q   <= 1'b0;
      hit_q    <= 1'b0;
    end else begin
      rdy_q   <= clk_on_q;
      runok_q <= run_q && rdy_q;
      if (ctrl_we) begin
        run_q    <= wdata[CTRL_RUN];
        clk_on_q <= wdata[CTRL_CLK];
        scale_q  <= wdata[CTRL_SCL_LSB +: SCALE_W];
        ie_q     <= wdata[CTRL_IE];
      end
      if (match_ev) run_q <= 1'b0;           // one-shot stop wins over a write
      if (cmp_we) cmp_r <= wdata;
      if (tick && !match_ev) cnt_r <= cnt_r + 1'b1;
      if (stat_we && wdata[ST_DONE]) done_q <= 1'b0;
      if (pend_q) begin
        cnt_r  <= pend_val;
        done_q <= 1'b1;
      end
      pend_q <= cnt_we;
      if (cnt_we) begin
        pend_val <= wdata;
        done_q   <= 1'b0;
      end
      if (stat_we && wdata[ST_HIT]) hit_q <= 1'b0;
      if (match_ev) hit_q <= 1'b1;
    end
  end

  always_comb begin
    ctrl_q = '0;
    ctrl_q[CTRL_RUN] = run_q;
    ctrl_q[CTRL_CLK] = clk_on_q;
    ctrl_q[CTRL_SCL_LSB +: SCALE_W] = scale_q;
    ctrl_q[CTRL_IE] = ie_q;
    stat_q = '0;
    stat_q[ST_HIT]  = hit_q;
    stat_q[ST_DONE] = done_q;
    stat_q[ST_RDY]  = rdy_q;
    stat_q[ST_RUN]  = runok_q;
  end

  assign cnt_q = cnt_r;
  assign cmp_q = cmp_r;
  assign irq_o = hit_q && ie_q;

  // R7: a match leaves the flag set and the half stopped
  a_r7_oneshot_stop: assert property (@(posedge clk) disable iff (!rst_n)
    match_ev |=> (hit_q && !run_q));

  // R10: a stopped half with no load pending holds its count
  a_r10_hold_count: assert property (@(posedge clk) disable iff (!rst_n)
    (!active && !pend_q) |=> $stable(cnt_r));

  // R5: a lone count write is followed by load done
  a_r5_done_after_load: assert property (@(posedge clk) disable iff (!rst_n)
    (cnt_we ##1 !cnt_we) |=> done_q);

  // R8: write-1-to-clear takes effect unless a match sets the flag
  a_r8_hit_clear: assert property (@(posedge clk) disable iff (!rst_n)
    (stat_we && wdata[ST_HIT] && !match_ev) |=> !hit_q);
endmodule

// File: rtl/split_oneshot_timer.sv
module split_oneshot_timer
  import halftmr_pkg::*;
#(
  parameter int HALF_W  = 16,
  parameter int MAX_EXP = 12
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                bus_we,
  input  logic [1:0]          bus_addr,
  input  logic [2*HALF_W-1:0] bus_wdata,
  output logic [2*HALF_W-1:0] bus_rdata,
  output logic                irq,
  output logic                irq_sel
);
  localparam int NHALF = 2;

  reg_sel_e          sel;
  logic [HALF_W-1:0] ctrl_h [NHALF];
  logic [HALF_W-1:0] cnt_h  [NHALF];
  logic [HALF_W-1:0] cmp_h  [NHALF];
  logic [HALF_W-1:0] stat_h [NHALF];
  logic [NHALF-1:0]  irq_pend;

  assign sel = reg_sel_e'(bus_addr);

  for (genvar h = 0; h < NHALF; h++) begin : g_half
    halftmr_unit #(.HALF_W(HALF_W), .MAX_EXP(MAX_EXP)) u_half (
      .clk    (clk),
      .rst_n  (rst_n),
      .ctrl_we(bus_we && (sel == REG_CTRL)),
      .cnt_we (bus_we && (sel == REG_COUNT)),
      .cmp_we (bus_we && (sel == REG_CMP)),
      .stat_we(bus_we && (sel == REG_STAT)),
      .wdata  (bus_wdata[h*HALF_W +: HALF_W]),
      .ctrl_q (ctrl_h[h]),
      .cnt_q  (cnt_h[h]),
      .cmp_q  (cmp_h[h]),
      .stat_q (stat_h[h]),
      .irq_o  (irq_pend[h])
    );
  end

  always_comb begin
    case (sel)
      REG_CTRL:  bus_rdata = {ctrl_h[1], ctrl_h[0]};
      REG_COUNT: bus_rdata = {cnt_h[1],  cnt_h[0]};
      REG_CMP:   bus_rdata = {cmp_h[1],  cmp_h[0]};
      default:   bus_rdata = {stat_h[1], stat_h[0]};
    endcase
  end

  assign irq     = |irq_pend;
  assign irq_sel = !irq_pend[0] && irq_pend[1];

  // R9: half A is served first when both halves are pending
  a_r9_a_first: assert property (@(posedge clk) disable iff (!rst_n)
    (irq_pend == 2'b11) |-> (irq && !irq_sel));
endmodule

// File: tb/split_oneshot_timer_tb.sv
module split_oneshot_timer_tb_top;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        we = 1'b0;
  logic [1:0]  addr = 2'd0;
  logic [31:0] wdata = '0;
  logic [31:0] rdata;
  logic        irq, irq_sel;
  int checks = 0;
  int errors = 0;
  logic [15:0] img_a = '0;
  logic [15:0] img_b = '0;

  always #10 clk = ~clk;

  split_oneshot_timer dut_i (
    .clk(clk), .rst_n(rst_n), .bus_we(we), .bus_addr(addr),
    .bus_wdata(wdata), .bus_rdata(rdata), .irq(irq), .irq_sel(irq_sel)
  );

  function automatic logic [15:0] ctl(input bit run, input bit ck, input int n, input bit ie);
    logic [15:0] v;
    v = '0;
    v[0] = run; v[1] = ck; v[5:2] = 4'(n); v[6] = ie;
    return v;
  endfunction

  function automatic int lat(input int cmp, input int start, input int n);
    int e;
    e = (n > 12) ? 12 : n;
    return (cmp - start) * (1 << e) + 1;
  endfunction

  task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual %h expected %h", tag, act, exp);
    end
  endtask

  task automatic wr(input logic [1:0] a, input logic [31:0] d);
    @(negedge clk);
    addr = a; wdata = d; we = 1'b1;
    @(posedge clk);
    #1 we = 1'b0;
  endtask

  task automatic rd(input logic [1:0] a, output logic [31:0] d);
    addr = a;
    #1 d = rdata;
  endtask

  task automatic wr_ctrl();
    wr(2'd0, {img_b, img_a});
  endtask

  // waits for the hit bit of one half, returns cycles after the last write edge
  task automatic wait_hit(input int half, output int n);
    logic [31:0] s;
    n = 0;
    forever begin
      @(posedge clk); #1;
      n++;
      rd(2'd3, s);
      if (s[half*16] || n > 6000) break;
    end
  endtask

  task automatic t_reset();
    logic [31:0] v;
    for (int a = 0; a < 4; a++) begin
      rd(2'(a), v);
      check($sformatf("R1 reg %0d after reset", a), v, 32'h0);
    end
    check("R1 irq after reset", {30'd0, irq, irq_sel}, 32'h0);
  endtask

  task automatic t_layout();
    logic [31:0] v;
    wr(2'd2, 32'h1234_5678);
    rd(2'd2, v);
    check("R2 compare readback", v, 32'h1234_5678);
    check("R2 half A field bits 15:0", {16'd0, v[15:0]}, 32'h5678);
  endtask

  task automatic t_ready();
    logic [31:0] v;
    img_a = ctl(0, 1, 0, 0); img_b = ctl(0, 1, 0, 0);
    wr_ctrl();
    rd(2'd3, v);
    check("R3 ready not yet", {30'd0, v[18], v[2]}, 32'h0);
    @(posedge clk); #1;
    rd(2'd3, v);
    check("R3 ready both halves", {30'd0, v[18], v[2]}, 32'h3);
  endtask

  task automatic t_load();
    logic [31:0] v;
    wr(2'd1, 32'h0007_0001);
    rd(2'd3, v);
    check("R5 done low right after write", {30'd0, v[17], v[1]}, 32'h0);
    rd(2'd1, v);
    check("R5 count not yet loaded", v, 32'h0);
    @(posedge clk); #1;
    rd(2'd1, v);
    check("R5 count loaded", v, 32'h0007_0001);
    rd(2'd3, v);
    check("R5 done set both", {30'd0, v[17], v[1]}, 32'h3);
    wr(2'd3, 32'h0000_0002);
    rd(2'd3, v);
    check("R5 done cleared for A only", {30'd0, v[17], v[1]}, 32'h2);
  endtask

  task automatic t_gate();
    logic [31:0] v, c0;
    img_a = ctl(0, 0, 0, 0);
    wr_ctrl();
    repeat (2) @(posedge clk);
    img_a = ctl(1, 0, 0, 0);
    wr_ctrl();
    rd(2'd1, c0);
    repeat (5) @(posedge clk);
    #1 rd(2'd1, v);
    check("R3 no count without clock ready", v, c0);
    rd(2'd3, v);
    check("R3 running stays low", {31'd0, v[3]}, 32'h0);
    img_a = ctl(0, 1, 0, 0);
    wr_ctrl();
    repeat (2) @(posedge clk);
  endtask

  task automatic t_running();
    logic [31:0] v;
    wr(2'd1, 32'h0000_0001);
    wr(2'd2, 32'h0000_03E8);
    img_a = ctl(1, 1, 0, 0);
    wr_ctrl();
    rd(2'd3, v);
    check("R4 running low in first cycle", {31'd0, v[3]}, 32'h0);
    @(posedge clk); #1;
    rd(2'd3, v);
    check("R4 running set", {31'd0, v[3]}, 32'h1);
    img_a = ctl(0, 1, 0, 0);
    wr_ctrl();
  endtask

  task automatic t_oneshot(input int n, input int cmp);
    logic [31:0] v;
    int got;
    wr(2'd1, 32'h0000_0001);
    wr(2'd2, {16'd0, 16'(cmp)});
    img_a = ctl(1, 1, n, 1);
    wr_ctrl();
    wait_hit(0, got);
    check($sformatf("R6 latency N=%0d C=%0d", n, cmp), got, lat(cmp, 1, n));
    rd(2'd1, v);
    check("R7 count held at compare", {16'd0, v[15:0]}, cmp);
    rd(2'd0, v);
    check("R7 run bit cleared", {31'd0, v[0]}, 32'h0);
    img_a[0] = 1'b0;
    wr(2'd3, 32'h0000_0001);
  endtask

  task automatic t_hold();
    logic [31:0] v;
    int got;
    wr(2'd1, 32'h0000_0001);
    wr(2'd2, 32'h0000_0064);
    img_a = ctl(1, 1, 0, 0);
    wr_ctrl();
    repeat (9) @(posedge clk);
    img_a = ctl(0, 1, 0, 0);
    wr_ctrl();
    repeat (6) @(posedge clk);
    #1 rd(2'd1, v);
    check("R10 count held after stop", {16'd0, v[15:0]}, 32'd11);
    img_a = ctl(1, 1, 0, 0);
    wr_ctrl();
    wait_hit(0, got);
    check("R10 resume latency", got, lat(100, 11, 0));
    img_a[0] = 1'b0;
    wr(2'd3, 32'h0000_0001);
  endtask

  task automatic t_indep();
    logic [31:0] v;
    int fa, fb;
    fa = 0; fb = 0;
    wr(2'd1, 32'h0001_0001);
    wr(2'd2, {16'd20, 16'd6});
    img_a = ctl(1, 1, 1, 1); img_b = ctl(1, 1, 0, 1);
    wr_ctrl();
    for (int n = 1; n <= 30; n++) begin
      @(posedge clk); #1;
      rd(2'd3, v);
      if (v[0] && fa == 0) fa = n;
      if (v[16] && fb == 0) fb = n;
    end
    check("R11 half A hit time", fa, lat(6, 1, 1));
    check("R11 half B hit time", fb, lat(20, 1, 0));
    img_a[0] = 1'b0; img_b[0] = 1'b0;
  endtask

  task automatic t_irq();
    logic [31:0] v;
    check("R9 both pending select A", {30'd0, irq, irq_sel}, 32'h2);
    wr(2'd3, 32'h0000_0001);
    rd(2'd3, v);
    check("R8 clear A keeps B", {30'd0, v[16], v[0]}, 32'h2);
    check("R9 only B pending", {30'd0, irq, irq_sel}, 32'h3);
    img_b = ctl(0, 1, 0, 0);
    wr_ctrl();
    check("R9 enable gates irq", {30'd0, irq, irq_sel}, 32'h0);
    rd(2'd3, v);
    check("R9 flag kept while gated", {31'd0, v[16]}, 32'h1);
    wr(2'd3, 32'h0001_0000);
    rd(2'd3, v);
    check("R8 clear B", {31'd0, v[16]}, 32'h0);
  endtask

  initial begin
    repeat (3) @(posedge clk);
    #1 rst_n = 1'b1;
    t_reset();
    t_layout();
    t_ready();
    t_load();
    t_gate();
    t_running();
    t_oneshot(0, 10);
    t_oneshot(2, 4);
    t_oneshot(15, 2);
    t_hold();
    t_indep();
    t_irq();
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    checks++;
    errors++;
    $display("FAIL watchdog expired");
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule